// File: doc/BRIEF.md
# Two-Buffer Program Page Cache Controller

The core executes only out of two on-chip instruction buffers. Each buffer holds one program page and carries a tag that names that page. This controller decides which buffer the core runs from. When a far jump, a call, a return or a run past the end of a buffer asks for a page that neither buffer holds, the controller copies that page byte by byte from external memory into a chosen buffer. The core is halted until the last byte has arrived.

A lock bit per buffer changes how the buffer to refill is chosen. A locked buffer is never chosen for a refill caused by program flow. When only the other buffer is free, that buffer takes every miss. When neither is free, a miss stops the core. A manual fill strobe loads any buffer, locked or not, so that software can pin pages in place before a run.

Each fill byte occupies one read slot of `ws_i + 1` cycles. A read request pulses on the first cycle of each slot. Instruction decode and the memory data path are outside this block.

Top module: `pgcache_ctl`

## Requirements
- R1: While reset is asserted and after it is released: halt_o, stop_o, run_o and rd_o are low and active_o is 0. Both buffer tags start invalid, so the first request for any page, page 0 included, misses and fills.
- R2: Each fill lasts exactly BUF_BYTES*(W+1) cycles with halt_o high, where W is ws_i sampled in the cycle the fill is accepted. rd_o pulses on the first cycle of each (W+1)-cycle slot. rd_addr_o is {page, byte offset}, with the offset in the low log2(BUF_BYTES) bits counting up from 0. rd_buf_o names the buffer being filled.
- R3: When idle (run_o low), jump_i starts execution. If buffer 0 holds req_page_i the core runs from buffer 0; otherwise, if buffer 1 holds it, from buffer 1. On a miss the controller fills buffer 0, or buffer 1 if lock_i[0] is set, and the core then runs from the filled buffer.
- R4: While running with no lock on the inactive buffer, a miss fills the inactive buffer and makes it active.
- R5: While running, a hit in the active buffer changes nothing. A hit in the inactive buffer switches active_o to it without a fill.
- R6: While running with the inactive buffer locked (lock_i bit equal to its index) and the active buffer unlocked, a miss refills the active buffer.
- R7: A call while running saves the active buffer's page as the return page; the return page is 0 after reset. A return looks up the saved page under the same hit/miss rules, so the caller's page is reloaded when it is no longer held.
- R8: A request that misses when no permitted buffer is unlocked raises stop_o for one cycle, drops run_o and starts no fill.
- R9: End of page (eop_i) while running in buffer 0 switches to buffer 1 if it holds req_page_i. Otherwise it fills buffer 1 with that page, or stops if lock_i[1] is set. End of page in buffer 1 always stops.
- R10: man_fill_i fills buffer man_sel_i with req_page_i even when that buffer is locked. It leaves run_o and active_o unchanged, and a later request for that page hits.
- R11: While halt_o is high, every strobe is ignored. While idle, call_i, ret_i and eop_i are ignored.
- R12: When several strobes arrive together, man_fill_i wins, then ret_i, call_i, jump_i and eop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_page_i | input | PAGE_W | Requested program page |
| jump_i | input | 1 | Far jump strobe |
| call_i | input | 1 | Far call strobe |
| ret_i | input | 1 | Return strobe |
| eop_i | input | 1 | Execution ran past the end of the active buffer |
| lock_i | input | 2 | Per-buffer lock, bit n locks buffer n |
| man_fill_i | input | 1 | Manual fill strobe |
| man_sel_i | input | 1 | Buffer for the manual fill |
| ws_i | input | WS_W | Waitstates per fill byte |
| halt_o | output | 1 | Core halted while a fill runs |
| stop_o | output | 1 | One-cycle stop pulse |
| run_o | output | 1 | Core is executing |
| active_o | output | 1 | Buffer the core executes from |
| rd_o | output | 1 | Fill byte read request |
| rd_buf_o | output | 1 | Buffer receiving the fill |
| rd_addr_o | output | PAGE_W+log2(BUF_BYTES) | Fill byte address {page, offset} |

## Verification
The bench sweeps all eight waitstate values and changes ws_i in the middle of each fill. A controller that re-read the count would stretch or shorten the halt and move the read pulses. Each lock pattern is paired with hits in either buffer and with misses. A wrong victim choice shows up as a fill of a locked buffer, a missing overwrite of the running buffer, or a missing stop when both are locked. Calls followed by returns after the caller's page has been evicted check that the saved page, not the requested one, is reloaded. Simultaneous strobes, strobes during a fill and idle-only strobes catch a wrong priority or a request leaking through a halt.

// File: rtl/pgcache_pkg.sv
package pgcache_pkg;
  localparam int unsigned NBUF = 2;

  typedef enum logic [1:0] {
    PG_NONE   = 2'd0,
    PG_SWITCH = 2'd1,
    PG_FILL   = 2'd2,
    PG_STOP   = 2'd3
  } pg_act_e;
endpackage

// File: rtl/pgcache_tags.sv
module pgcache_tags
  import pgcache_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned IDX_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [PAGE_W-1:0] set_page,
  input  logic [PAGE_W-1:0] look_page,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [NBUF-1:0]   hit_o,
  output logic [PAGE_W-1:0] rd_tag_o
);
  logic [PAGE_W-1:0] tag_q   [NBUF];
  logic              valid_q [NBUF];

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_entry
    logic set_me;
    logic clr_me;
    assign set_me = set_en && (set_idx == IDX_W'(gi));
    assign clr_me = clr_en && (clr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[gi] <= 1'b0;
        tag_q[gi]   <= '0;
      end else if (set_me) begin
        valid_q[gi] <= 1'b1;
        tag_q[gi]   <= set_page;
      end else if (clr_me) begin
        valid_q[gi] <= 1'b0;
      end
    end

    assign hit_o[gi] = valid_q[gi] && (tag_q[gi] == look_page);
  end

  assign rd_tag_o = tag_q[rd_idx];
endmodule

// File: rtl/pgcache_policy.sv
module pgcache_policy
  import pgcache_pkg::*;
(
  input  logic [1:0] hit_i,
  input  logic [1:0] lock_i,
  input  logic       run_i,
  input  logic       active_i,
  input  logic       eop_i,
  output pg_act_e    act_o,
  output logic       idx_o
);
  logic other;
  logic pref;

  assign other = ~active_i;
  assign pref  = run_i ? other : 1'b0;

  always_comb begin
    act_o = PG_NONE;
    idx_o = active_i;
    if (eop_i) begin
      if (active_i) begin
        act_o = PG_STOP;
      end else if (hit_i[1]) begin
        act_o = PG_SWITCH;
        idx_o = 1'b1;
      end else if (!lock_i[1]) begin
        act_o = PG_FILL;
        idx_o = 1'b1;
      end else begin
        act_o = PG_STOP;
      end
    end else if (run_i && hit_i[active_i]) begin
      act_o = PG_NONE;
    end else if (run_i && hit_i[other]) begin
      act_o = PG_SWITCH;
      idx_o = other;
    end else if (!run_i && hit_i[0]) begin
      act_o = PG_SWITCH;
      idx_o = 1'b0;
    end else if (!run_i && hit_i[1]) begin
      act_o = PG_SWITCH;
      idx_o = 1'b1;
    end else if (!lock_i[pref]) begin
      act_o = PG_FILL;
      idx_o = pref;
    end else if (!lock_i[~pref]) begin
      act_o = PG_FILL;
      idx_o = ~pref;
    end else begin
      act_o = PG_STOP;
    end
  end
endmodule

// File: rtl/pgcache_fill.sv
module pgcache_fill #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned BUF_BYTES = 512,
  parameter int unsigned WS_W      = 3,
  localparam int unsigned OFS_W    = $clog2(BUF_BYTES),
  localparam int unsigned ADDR_W   = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_buf_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic [WS_W-1:0]   ws_i,
  output logic              busy_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              buf_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              done_o
);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BUF_BYTES - 1);

  logic              busy_q, busy_d;
  logic              buf_q, buf_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [WS_W-1:0]   wcnt_q, wcnt_d;
  logic [WS_W-1:0]   wsl_q, wsl_d;
  logic              slot_end, last_byte, upd_en;

  assign slot_end  = (wcnt_q == wsl_q);
  assign last_byte = (ofs_q == LAST_OFS);
  assign upd_en    = start_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    buf_d  = buf_q;
    page_d = page_q;
    ofs_d  = ofs_q;
    wcnt_d = wcnt_q;
    wsl_d  = wsl_q;
    if (start_i) begin
      busy_d = 1'b1;
      buf_d  = start_buf_i;
      page_d = start_page_i;
      ofs_d  = '0;
      wcnt_d = '0;
      wsl_d  = ws_i;
    end else if (busy_q) begin
      if (slot_end) begin
        wcnt_d = '0;
        if (last_byte) busy_d = 1'b0;
        else           ofs_d  = ofs_q + 1'b1;
      end else begin
        wcnt_d = wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      buf_q  <= 1'b0;
      page_q <= '0;
      ofs_q  <= '0;
      wcnt_q <= '0;
      wsl_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      buf_q  <= buf_d;
      page_q <= page_d;
      ofs_q  <= ofs_d;
      wcnt_q <= wcnt_d;
      wsl_q  <= wsl_d;
    end
  end

  assign busy_o    = busy_q;
  assign rd_o      = busy_q && (wcnt_q == '0);
  assign rd_addr_o = {page_q, ofs_q};
  assign buf_o     = buf_q;
  assign page_o    = page_q;
  assign done_o    = busy_q && slot_end && last_byte;
endmodule

// File: rtl/pgcache_ctl.sv
module pgcache_ctl
  import pgcache_pkg::*;
#(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned BUF_BYTES = 512,
  parameter int unsigned WS_W      = 3,
  localparam int unsigned OFS_W    = $clog2(BUF_BYTES),
  localparam int unsigned ADDR_W   = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              eop_i,
  input  logic [1:0]        lock_i,
  input  logic              man_fill_i,
  input  logic              man_sel_i,
  input  logic [WS_W-1:0]   ws_i,
  output logic              halt_o,
  output logic              stop_o,
  output logic              run_o,
  output logic              active_o,
  output logic              rd_o,
  output logic              rd_buf_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  logic              busy, done, fbuf;
  logic [PAGE_W-1:0] fpage;
  logic [1:0]        hit;
  logic [PAGE_W-1:0] act_tag;
  pg_act_e           pact;
  logic              pidx;

  logic              run_q, run_d, act_q, act_d, stop_q, stop_d;
  logic [PAGE_W-1:0] ret_q, ret_d;

  logic sel_ok, man_go, ret_go, call_go, jump_go, eop_go, req_go;
  logic fill_start, start_buf;
  logic [PAGE_W-1:0] look_page, start_page;

  // request acceptance, in priority order
  assign man_go  = !busy && man_fill_i;
  assign sel_ok  = !busy && !man_fill_i;
  assign ret_go  = sel_ok && run_q && ret_i;
  assign call_go = sel_ok && run_q && !ret_i && call_i;
  assign jump_go = sel_ok && jump_i && !(run_q && (ret_i || call_i));
  assign eop_go  = sel_ok && run_q && eop_i && !ret_i && !call_i && !jump_i;
  assign req_go  = ret_go || call_go || jump_go || eop_go;

  assign look_page  = ret_go ? ret_q : req_page_i;
  assign fill_start = man_go || (req_go && (pact == PG_FILL));
  assign start_buf  = man_go ? man_sel_i : pidx;
  assign start_page = man_go ? req_page_i : look_page;

  pgcache_tags #(.PAGE_W(PAGE_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_in_n),
    .clr_en    (fill_start),
    .clr_idx   (start_buf),
    .set_en    (done),
    .set_idx   (fbuf),
    .set_page  (fpage),
    .look_page (look_page),
    .rd_idx    (act_q),
    .hit_o     (hit),
    .rd_tag_o  (act_tag)
  );

  pgcache_policy u_policy (
    .hit_i    (hit),
    .lock_i   (lock_i),
    .run_i    (run_q),
    .active_i (act_q),
    .eop_i    (eop_go),
    .act_o    (pact),
    .idx_o    (pidx)
  );

  pgcache_fill #(
    .PAGE_W    (PAGE_W),
    .BUF_BYTES (BUF_BYTES),
    .WS_W      (WS_W)
  ) u_fill (
    .clk          (clk),
    .rst_n        (rst_in_n),
    .start_i      (fill_start),
    .start_buf_i  (start_buf),
    .start_page_i (start_page),
    .ws_i         (ws_i),
    .busy_o       (busy),
    .rd_o         (rd_o),
    .rd_addr_o    (rd_addr_o),
    .buf_o        (fbuf),
    .page_o       (fpage),
    .done_o       (done)
  );

  always_comb begin
    run_d  = run_q;
    act_d  = act_q;
    ret_d  = ret_q;
    stop_d = 1'b0;
    if (req_go) begin
      if (call_go) ret_d = act_tag;
      unique case (pact)
        PG_SWITCH, PG_FILL: begin
          run_d = 1'b1;
          act_d = pidx;
        end
        PG_STOP: begin
          run_d  = 1'b0;
          stop_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      ret_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      stop_q <= stop_d;
      if (req_go) begin
        run_q <= run_d;
        act_q <= act_d;
        ret_q <= ret_d;
      end
    end
  end

  assign halt_o   = busy;
  assign stop_o   = stop_q;
  assign run_o    = run_q;
  assign active_o = act_q;
  assign rd_buf_o = fbuf;
endmodule

// File: rtl/pgcache_ctl_chk.sv
module pgcache_ctl_chk #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 9,
  localparam int unsigned ADDR_W = PAGE_W + OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        lock_i,
  input logic              man_fill_i,
  input logic              halt_o,
  input logic              stop_o,
  input logic              run_o,
  input logic              active_o,
  input logic              rd_o,
  input logic              rd_buf_o,
  input logic [ADDR_W-1:0] rd_addr_o
);
  assert_rd_in_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> halt_o);

  assert_first_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_o) |-> (rd_o && (rd_addr_o[OFS_W-1:0] == '0)));

  assert_fill_target_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && $past(halt_o)) |-> ($stable(rd_buf_o) && $stable(rd_addr_o[ADDR_W-1:OFS_W])));

  // a fill not started manually never targets a buffer locked when it began
  assert_lock_respected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(halt_o) && !$past(man_fill_i)) |-> (($past(lock_i) & (2'b01 << rd_buf_o)) == 2'b00));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!run_o && !halt_o));

  assert_run_falls_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_o) |-> stop_o);

  assert_frozen_in_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && $past(halt_o)) |-> ($stable(run_o) && $stable(active_o)));
endmodule

bind pgcache_ctl pgcache_ctl_chk #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_i     (lock_i),
  .man_fill_i (man_fill_i),
  .halt_o     (halt_o),
  .stop_o     (stop_o),
  .run_o      (run_o),
  .active_o   (active_o),
  .rd_o       (rd_o),
  .rd_buf_o   (rd_buf_o),
  .rd_addr_o  (rd_addr_o)
);

// File: tb/pgcache_ctl_tb.sv
module pgcache_ctl_tb;
  localparam int unsigned PW = 3;
  localparam int unsigned NB = 4;
  localparam int unsigned OW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] req_page_i;
  logic          jump_i, call_i, ret_i, eop_i;
  logic [1:0]    lock_i;
  logic          man_fill_i, man_sel_i;
  logic [2:0]    ws_i;
  logic          halt_o, stop_o, run_o, active_o, rd_o, rd_buf_o;
  logic [PW+OW-1:0] rd_addr_o;

  always #2.5 clk = ~clk;

  pgcache_ctl #(.PAGE_W(PW), .BUF_BYTES(NB), .WS_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_page_i(req_page_i), .jump_i(jump_i),
    .call_i(call_i), .ret_i(ret_i), .eop_i(eop_i), .lock_i(lock_i),
    .man_fill_i(man_fill_i), .man_sel_i(man_sel_i), .ws_i(ws_i),
    .halt_o(halt_o), .stop_o(stop_o), .run_o(run_o), .active_o(active_o),
    .rd_o(rd_o), .rd_buf_o(rd_buf_o), .rd_addr_o(rd_addr_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done_flag = 0;

  // bench model of the expected state
  logic          m_val [2];
  logic [PW-1:0] m_tag [2];
  logic          m_run, m_act;
  logic [PW-1:0] m_ret;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // msk: bit0 jump, bit1 call, bit2 ret, bit3 end of page
  task automatic op(input logic [3:0] msk, input logic man, input logic msel,
                    input logic [PW-1:0] pg, input logic [1:0] lk,
                    input logic [2:0] ws, input string note);
    int kind;
    logic [PW-1:0] tgt, saved;
    logic h0, h1, hA, hO, e_fill, e_stop, fb, pref;
    string rq;
    int slot, total;
    e_fill = 0; e_stop = 0; fb = 0; rq = "R11"; kind = 0;
    if (man) kind = 5;
    else if (m_run) begin
      if (msk[2]) kind = 3;
      else if (msk[1]) kind = 2;
      else if (msk[0]) kind = 1;
      else if (msk[3]) kind = 4;
    end else if (msk[0]) kind = 1;
    tgt = (kind == 3) ? m_ret : pg;
    saved = m_tag[m_act];
    h0 = m_val[0] && (m_tag[0] == tgt);
    h1 = m_val[1] && (m_tag[1] == tgt);
    if (kind == 5) begin
      rq = "R10"; e_fill = 1; fb = msel;
    end else if (kind == 4) begin
      rq = "R9";
      if (m_act) e_stop = 1;
      else if (h1) m_act = 1'b1;
      else if (!lk[1]) begin e_fill = 1; fb = 1'b1; end
      else e_stop = 1;
    end else if (kind != 0) begin
      rq = (kind == 1) ? (m_run ? "R4" : "R3") : "R7";
      hA = m_act ? h1 : h0;
      hO = m_act ? h0 : h1;
      if (m_run && hA) rq = {rq, "/R5"};
      else if (m_run && hO) begin m_act = ~m_act; rq = {rq, "/R5"}; end
      else if (!m_run && h0) begin m_run = 1'b1; m_act = 1'b0; end
      else if (!m_run && h1) begin m_run = 1'b1; m_act = 1'b1; end
      else begin
        pref = m_run ? ~m_act : 1'b0;
        if (!lk[pref]) begin e_fill = 1; fb = pref; end
        else if (!lk[~pref]) begin e_fill = 1; fb = ~pref; rq = {rq, "/R6"}; end
        else begin e_stop = 1; rq = {rq, "/R8"}; end
      end
      if (kind == 2) m_ret = saved;
    end
    if (e_fill && kind != 5) begin m_run = 1'b1; m_act = fb; end
    if (e_fill) begin m_val[fb] = 1'b1; m_tag[fb] = (kind == 3) ? tgt : pg; end
    if (e_stop) m_run = 1'b0;
    if (msk != 0 && man) rq = {rq, "/R12"};
    rq = {rq, " ", note};

    @(negedge clk);
    jump_i = msk[0]; call_i = msk[1]; ret_i = msk[2]; eop_i = msk[3];
    man_fill_i = man; man_sel_i = msel; req_page_i = pg; lock_i = lk; ws_i = ws;
    @(negedge clk);
    jump_i = 0; call_i = 0; ret_i = 0; eop_i = 0; man_fill_i = 0;
    if (e_stop) begin
      chk(stop_o == 1'b1, {rq, " stop pulse"}, int'(stop_o), 1);
      chk(halt_o == 1'b0, {rq, " no fill on stop"}, int'(halt_o), 0);
      @(negedge clk);
      chk(stop_o == 1'b0, {rq, " stop one cycle"}, int'(stop_o), 0);
    end else begin
      chk(stop_o == 1'b0, {rq, " no stop"}, int'(stop_o), 0);
    end
    if (e_fill) begin
      slot = int'(ws) + 1;
      total = int'(NB) * slot;
      for (int i = 0; i < total; i++) begin
        chk(halt_o == 1'b1, {"R2 halt ", rq}, int'(halt_o), 1);
        chk(rd_o == ((i % slot) == 0), {"R2 read slot ", rq}, int'(rd_o), int'((i % slot) == 0));
        if ((i % slot) == 0) begin
          chk(rd_addr_o == {m_tag[fb], OW'(i / slot)}, {"R2 addr ", rq},
              int'(rd_addr_o), int'({m_tag[fb], OW'(i / slot)}));
          chk(rd_buf_o == fb, {"R2 buffer ", rq}, int'(rd_buf_o), int'(fb));
        end
        if (i == 0) ws_i = ~ws;
        if (i == 1) begin jump_i = 1; req_page_i = pg + 1'b1; end
        if (i == 2) jump_i = 0;
        @(negedge clk);
      end
      chk(halt_o == 1'b0, {"R2 fill length ", rq}, int'(halt_o), 0);
      chk(stop_o == 1'b0, {"R11 strobe during fill ", rq}, int'(stop_o), 0);
    end else begin
      chk(halt_o == 1'b0, {rq, " no halt"}, int'(halt_o), 0);
    end
    chk(run_o == m_run, {rq, " run"}, int'(run_o), int'(m_run));
    chk(active_o == m_act, {rq, " active"}, int'(active_o), int'(m_act));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] seed;
    rst_n = 0; req_page_i = 0; jump_i = 0; call_i = 0; ret_i = 0; eop_i = 0;
    lock_i = 0; man_fill_i = 0; man_sel_i = 0; ws_i = 0;
    m_val[0] = 0; m_val[1] = 0; m_tag[0] = 0; m_tag[1] = 0;
    m_run = 0; m_act = 0; m_ret = 0;
    repeat (3) @(negedge clk);
    chk(halt_o == 0 && stop_o == 0 && run_o == 0 && rd_o == 0 && active_o == 0,
        "R1 outputs in reset", int'({halt_o, stop_o, run_o, rd_o, active_o}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(halt_o == 0 && stop_o == 0 && run_o == 0 && rd_o == 0 && active_o == 0,
        "R1 outputs after reset", int'({halt_o, stop_o, run_o, rd_o, active_o}), 0);

    // page 0 equals the reset tag value yet must miss (R1)
    op(4'b0001, 0, 0, 3'd0, 2'b00, 3'd0, "R1 first lookup misses");
    op(4'b1000, 0, 0, 3'd5, 2'b00, 3'd1, "R9 eop fills buffer 1");
    op(4'b1000, 0, 0, 3'd2, 2'b00, 3'd0, "R9 eop in buffer 1 stops");
    op(4'b1110, 0, 0, 3'd3, 2'b00, 3'd0, "R11 idle ignores call ret eop");

    // exhaustive waitstate sweep through manual fills of locked buffers
    for (int w = 0; w < 8; w++)
      op(4'b0000, 1, w[0], 3'(w), 2'b11, 3'(w), "R10 manual fill locked");
    op(4'b0001, 0, 0, 3'd7, 2'b11, 3'd0, "R3 idle hit buffer 1");
    op(4'b0001, 0, 0, 3'd6, 2'b11, 3'd0, "R5 hit other buffer");
    op(4'b0001, 0, 0, 3'd2, 2'b11, 3'd0, "R8 both locked miss");

    // one locked: call and return reload through the running buffer
    op(4'b0001, 0, 0, 3'd4, 2'b01, 3'd2, "R3 idle miss with buffer 0 locked");
    op(4'b0010, 0, 0, 3'd1, 2'b01, 3'd1, "R6 call overwrites running buffer");
    op(4'b0100, 0, 0, 3'd0, 2'b01, 3'd3, "R7 return reloads caller page");
    op(4'b1001, 0, 0, 3'd3, 2'b00, 3'd0, "R12 jump beats eop");
    op(4'b0110, 0, 0, 3'd5, 2'b00, 3'd0, "R12 ret beats call");
    op(4'b0001, 1, 1, 3'd2, 2'b00, 3'd1, "R12 manual beats jump");
    op(4'b0001, 0, 0, 3'd6, 2'b00, 3'd0, "R4 unlocked miss fills other");

    seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [3:0] msk;
      seed = seed * 32'd1664525 + 32'd1013904223;
      msk = seed[11:8];
      op(msk, seed[14:12] == 3'd0, seed[15], seed[18:16],
         {seed[20] & seed[21], seed[22] & seed[23]}, seed[26:24], "sweep");
    end
    summary();
  end
endmodule